// File: doc/BRIEF.md
# Latched Interrupt Source Controller

This block collects up to six event lines, typically the outputs of timers and the handshake bits of parallel ports, into one byte-wide register that a host reaches through a simple strobe-based port. One register address has two meanings. A write to it loads a per-source enable mask. A read from it returns the latched event flags. A rising edge on an enabled source sets that source's flag, and the flag stays set until the host removes the enable for that source. There is no separate acknowledge register.

The block drives one interrupt request line. A static mode input selects how that line behaves. In level mode the request follows the whole flag word being non-zero. In pulse mode the request is a single-clock strobe that fires when the flag word leaves zero, and it does not fire again until the word has been cleared back to zero. Source lines may be asynchronous to the block clock, so each one is synchronised before its edges are detected.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, the enable mask and the flag word are zero, `irq_req` is low and `host_rdata` is zero.
- R2: A rising edge on `evt_src[i]` whose enable bit is 1 sets flag bit i. A source driven high between two clock edges appears in the flag word after the third following rising clock edge (two synchroniser stages plus one delay stage).
- R3: A rising edge on a source whose enable bit is 0 leaves the flag word unchanged.
- R4: A set flag bit stays set, whatever its source does, as long as its enable bit stays 1. A write that puts 0 into enable bit i clears flag bit i at the same clock edge that loads the mask.
- R5: When `host_rd` is high with `host_addr` equal to REG_OFFSET (default 0x1E, inside a 32-byte window), `host_rdata` holds the flag word in bits 5:0 one cycle later, with bits 7:6 at zero. In all other cycles `host_rdata` is zero.
- R6: A write with `host_wr` high to any address other than REG_OFFSET leaves both the enable mask and the flag word unchanged.
- R7: In level mode (`irq_pulse_mode` = 0), `irq_req` is high exactly while the flag word is non-zero.
- R8: In pulse mode (`irq_pulse_mode` = 1), `irq_req` is high for one cycle when the flag word goes from zero to non-zero. More flags set while the word is still non-zero raise no further pulse. Once the word has been cleared to zero, the next set flag pulses again.
- R9: A source that stays high creates only one event. Clearing and then restoring its enable does not set its flag again until the source falls and rises once more.
- R10: Write data bits 7:6 are ignored and enable no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_src | input | 6 | Raw event source lines, may be asynchronous |
| host_addr | input | 5 | Byte address inside the register window |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Write data; bits 5:0 form the enable mask |
| host_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| irq_pulse_mode | input | 1 | 0 selects level request, 1 selects single-cycle pulse |
| irq_req | output | 1 | Interrupt request to the host |

## Verification
Both the enable mask and the flag word are hidden state. A wrong mask bit therefore appears only through its effect. A flag is missed or wrongly set three cycles after a source edge, and in level mode `irq_req` shows it at the same edge. A flag that fails to clear, or clears on its own, is seen at the next read and also on `irq_req` in level mode. A wrong record of the previous zero state in pulse mode shows up as an extra or a missing pulse in the cycle the flag word leaves zero. The bench runs a behavioural model that shifts source samples through a history and compares `host_rdata` and `irq_req` after every clock edge, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // Request line behaviour
    typedef enum logic {
        IRQ_LEVEL = 1'b0,
        IRQ_PULSE = 1'b1
    } irq_mode_e;

    // One host access as seen by the decoder
    typedef struct packed {
        logic wr_hit;
        logic rd_hit;
    } host_hit_t;

    // Address match helper
    function automatic logic addr_match(input logic [7:0] addr, input logic [7:0] offset);
        return addr == offset;
    endfunction

endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
    parameter int NUM_SRC     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_raw,
    output logic [NUM_SRC-1:0] src_rise
);
    localparam int TOP = SYNC_STAGES - 1;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   delay_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q  <= '0;
                delay_q <= 1'b0;
            end else begin
                sync_q  <= {sync_q[TOP-1:0], src_raw[g]};
                delay_q <= sync_q[TOP];
            end
        end

        assign src_rise[g] = sync_q[TOP] & ~delay_q;
    end

    // An edge strobe can never be high in two consecutive cycles
    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((src_rise & $past(src_rise)) == '0)); // R9

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_rise,
    input  logic               mask_load,
    input  logic [NUM_SRC-1:0] mask_value,
    output logic [NUM_SRC-1:0] enable_q,
    output logic [NUM_SRC-1:0] flags_q
);
    logic [NUM_SRC-1:0] enable_d;
    logic [NUM_SRC-1:0] flags_d;

    always_comb begin
        enable_d = mask_load ? mask_value : enable_q;
        flags_d  = (flags_q | src_rise) & enable_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            flags_q  <= '0;
        end else begin
            enable_q <= enable_d;
            flags_q  <= flags_d;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (enable_q == '0 && flags_q == '0)); // R1

    AST_FLAGS_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        (flags_q & ~enable_q) == '0); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((flags_q & $past(flags_q)) == ($past(flags_q) & enable_q))); // R4

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((flags_q & ~$past(flags_q) & ~$past(src_rise)) == '0)); // R3

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
    import irq_latch_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  irq_mode_e          mode,
    input  logic [NUM_SRC-1:0] flags,
    output logic               irq
);
    logic any_now;
    logic any_prev_q;

    assign any_now = |flags;

    always_ff @(posedge clk) begin
        if (rst) any_prev_q <= 1'b0;
        else     any_prev_q <= any_now;
    end

    always_comb begin
        unique case (mode)
            IRQ_LEVEL: irq = any_now;
            IRQ_PULSE: irq = any_now & ~any_prev_q;
            default:   irq = 1'b0;
        endcase
    end

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode == IRQ_LEVEL && flags != '0) |-> irq); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode == IRQ_PULSE && irq) |=> !irq); // R8

    AST_PULSE_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rst ##1 (mode == IRQ_PULSE && irq) |-> $past(flags) == '0); // R8

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int NUM_SRC     = 6,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int REG_OFFSET  = 'h1E
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_src,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               irq_pulse_mode,
    output logic               irq_req
);
    localparam logic [7:0] OFFSET8 = 8'(REG_OFFSET);
    localparam int         PAD_W   = DATA_W - NUM_SRC;

    host_hit_t          hit;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] flags;
    logic               unused_wdata_hi;
    irq_mode_e          mode;

    assign hit.wr_hit      = host_wr & addr_match(8'(host_addr), OFFSET8);
    assign hit.rd_hit      = host_rd & addr_match(8'(host_addr), OFFSET8);
    assign unused_wdata_hi = ^host_wdata[DATA_W-1:NUM_SRC];
    assign mode            = irq_mode_e'(irq_pulse_mode);

    irq_src_edge #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .src_raw  (evt_src),
        .src_rise (rise)
    );

    irq_status_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .src_rise   (rise),
        .mask_load  (hit.wr_hit),
        .mask_value (host_wdata[NUM_SRC-1:0]),
        .enable_q   (enable),
        .flags_q    (flags)
    );

    irq_req_gen #(
        .NUM_SRC (NUM_SRC)
    ) u_req (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .flags (flags),
        .irq   (irq_req)
    );

    always_ff @(posedge clk) begin
        if (rst)              host_rdata <= '0;
        else if (hit.rd_hit)  host_rdata <= {{PAD_W{1'b0}}, flags};
        else                  host_rdata <= '0;
    end

    AST_RDATA_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        host_rdata[DATA_W-1:NUM_SRC] == '0); // R5

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hit.rd_hit |=> host_rdata == '0); // R5

    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !hit.wr_hit && !host_rd) |=> $stable(enable)); // R6

endmodule

// File: tb/tb_irq_latch_ctrl.sv
`timescale 1ns/1ps
module tb_irq_latch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] OFF = 5'h1E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] evt_src = '0;
    logic [4:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_pulse_mode = 1'b0;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    irq_latch_ctrl dut (
        .clk            (clk),
        .rst            (rst),
        .evt_src        (evt_src),
        .host_addr      (host_addr),
        .host_wr        (host_wr),
        .host_rd        (host_rd),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .irq_pulse_mode (irq_pulse_mode),
        .irq_req        (irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: sample history of the sources, mask, flags
    logic [5:0] m_h0 = '0, m_h1 = '0, m_h2 = '0;
    logic [5:0] m_en = '0, m_st = '0;
    logic [7:0] m_rd = '0;
    logic       m_irq = 1'b0;

    always @(posedge clk) begin
        logic [5:0] rise;
        logic [5:0] old;
        if (rst) begin
            m_h0 = '0; m_h1 = '0; m_h2 = '0;
            m_en = '0; m_st = '0; m_rd = '0; m_irq = 1'b0;
        end else begin
            rise = m_h1 & ~m_h2;
            old  = m_st;
            m_rd = (host_rd && host_addr == OFF) ? {2'b00, old} : 8'h00;
            if (host_wr && host_addr == OFF) m_en = host_wdata[5:0];
            m_st = (m_st | rise) & m_en;
            if (irq_pulse_mode) m_irq = (m_st != 0) && (old == 0);
            else                m_irq = (m_st != 0);
            m_h2 = m_h1; m_h1 = m_h0; m_h0 = evt_src;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (!done) begin
            check("R5 model rdata", 32'(host_rdata), 32'(m_rd));
            if (irq_pulse_mode) check("R8 model irq", 32'(irq_req), 32'(m_irq));
            else                check("R7 model irq", 32'(irq_req), 32'(m_irq));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_expect(input string tag, input logic [7:0] exp);
        @(negedge clk);
        host_addr = OFF; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check(tag, 32'(host_rdata), 32'(exp));
    endtask

    task automatic pulse_src(input int idx);
        @(negedge clk);
        evt_src[idx] = 1'b1;
        idle(2);
        evt_src[idx] = 1'b0;
    endtask

    task automatic count_irq(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_req) cnt++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        idle(3);
        check("R1 rdata in reset", 32'(host_rdata), 0);
        check("R1 irq in reset", 32'(irq_req), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq after reset", 32'(irq_req), 0);
        read_expect("R1 flags after reset", 8'h00);

        // Level mode, enable all but source 1, upper bits set (R10)
        reg_write(OFF, 8'hFD);
        @(negedge clk); evt_src[0] = 1'b1;
        idle(4);
        read_expect("R2 source 0 latched", 8'h01);
        check("R7 irq high with flags", 32'(irq_req), 1);

        pulse_src(1);
        idle(4);
        read_expect("R3 disabled source 1", 8'h01);

        evt_src[0] = 1'b0; idle(3);
        read_expect("R4 sticky after source falls", 8'h01);

        reg_write(5'h00, 8'h00);
        reg_write(5'h1F, 8'h00);
        read_expect("R6 foreign write ignored", 8'h01);
        pulse_src(2); idle(4);
        read_expect("R6 mask kept after foreign write", 8'h05);

        reg_write(OFF, 8'h3A);
        idle(1);
        read_expect("R4 clear by mask", 8'h00);
        check("R7 irq low when flags zero", 32'(irq_req), 0);

        // Held source gives one event only
        reg_write(OFF, 8'h3C);
        @(negedge clk); evt_src[2] = 1'b1;
        idle(4);
        read_expect("R9 held source first edge", 8'h04);
        reg_write(OFF, 8'h38);
        reg_write(OFF, 8'h3C);
        idle(4);
        read_expect("R9 held source no second event", 8'h00);
        evt_src[2] = 1'b0; idle(3);

        // Upper write bits enable nothing
        reg_write(OFF, 8'hC0);
        pulse_src(3); pulse_src(4); idle(4);
        read_expect("R10 upper bits ignored", 8'h00);
        check("R10 irq stays low", 32'(irq_req), 0);

        // Pulse mode
        irq_pulse_mode = 1'b1;
        reg_write(OFF, 8'h3F);
        idle(2);
        fork
            pulse_src(3);
            count_irq(8, cnt);
        join
        check("R8 one pulse on first flag", 32'(cnt), 1);
        fork
            pulse_src(4);
            count_irq(8, cnt);
        join
        check("R8 no pulse while non-zero", 32'(cnt), 0);
        read_expect("R8 both flags held", 8'h18);
        reg_write(OFF, 8'h00);
        reg_write(OFF, 8'h3F);
        idle(2);
        fork
            pulse_src(5);
            count_irq(8, cnt);
        join
        check("R8 pulse again after clear", 32'(cnt), 1);
        read_expect("R2 source 5 latched", 8'h20);

        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule